// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block collects sixteen interrupt request lines into one pending word, gates them with a per-source enable word, and turns the most urgent surviving request into a byte code that software can add straight to the base of a handler table. Eight of the lines come from on-chip peripherals and eight from device pins. The two kinds share the pending word in alternating bit positions, so one read shows both kinds.

A single registered request line goes to the processor. The handler reads the vector code, jumps through the table, and clears a pin-sourced request by writing a one to its pending bit. Peripheral-sourced requests are level lines. They drop when the peripheral itself is serviced. The pending word, the enable word and the vector code sit behind a small word-wide register port with combinational reads.

Top module: `vec_irq_ctrl`

## Requirements
- R1: The pending word is read at select 0. Bit 2k holds pin source k and bit 2k+1 holds peripheral source k, for k = 0..7.
- R2: A pending bit is shown whether or not its enable bit is set.
- R3: A rising edge on pin source k sets pending bit 2k one clock later. The bit stays set while its line is low or held high. Writing 1 to bit 2k at select 0 clears it, and writing 0 leaves it alone. A held-high line does not set the bit again after a clear. An edge in the same cycle as a clearing write leaves the bit set.
- R4: Pending bit 2k+1 equals peripheral line k as sampled on the previous clock. Writes to these bits have no effect.
- R5: The enable word is read and written at select 1 as 16 bits, one per source, and resets to 0. It changes only on a write to select 1.
- R6: The output `irq_o` is high exactly when, one clock earlier, some pending bit had its enable bit set.
- R7: At select 2 the low byte reads 4 times the index of the lowest-numbered bit that is pending and enabled, as it stood one clock earlier. Bit 0 wins over all others. The upper byte reads 0.
- R8: When no enabled source is pending, the vector reads 0xFF and `irq_o` is low. After reset the pending word is 0, the enable word is 0, the vector is 0xFF and `irq_o` is low.
- R9: Select 3 reads 0. Writes to select 2 or select 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_req_i | input | 8 | Peripheral request lines, level-sensitive |
| ext_req_i | input | 8 | Pin request lines, rising-edge sensitive |
| bus_sel_i | input | 2 | Register select: 0 pending, 1 enable, 2 vector, 3 reserved |
| bus_wr_i | input | 1 | Write strobe for the selected register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the selected register, combinational |
| irq_o | output | 1 | Registered request to the processor |

## Verification
A table drives the vector path with these patterns:
- No source active.
- A single pin source or a single peripheral source, to show which slot each kind lands in.
- The two highest-index sources, to exercise the top codes.
- Every line raised while every enable is cleared, to show that pending bits stay visible behind a zero enable word.
- Scattered sources, first with all enables set and then with the winning bits masked, to show that the winner moves to the next enabled bit.

Directed sequences then cover the corner cases:
- A one-cycle pulse on a pin line against a held-high pin line.
- Writes of 0 and of 1 to a sticky bit.
- A clear that lands in the same cycle as a new edge.
- Writes aimed at the level bits, the vector and the reserved select, which must not change any state.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   typedef enum logic [1:0] {
      SEL_PEND = 2'd0,
      SEL_MASK = 2'd1,
      SEL_VEC  = 2'd2,
      SEL_RSVD = 2'd3
   } reg_sel_e;

   localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/irqc_pending.sv
module irqc_pending #(
   parameter  int unsigned PAIRS = 8,
   localparam int unsigned W     = 2 * PAIRS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PAIRS-1:0] ext_lines,
   input  logic [PAIRS-1:0] int_lines,
   input  logic             clr_en,
   input  logic [PAIRS-1:0] clr_ext,
   output logic [W-1:0]     pend_q
);

   logic [PAIRS-1:0] ext_prev_q;
   logic [PAIRS-1:0] ext_rise;
   logic [W-1:0]     pend_d;

   for (genvar k = 0; k < PAIRS; k++) begin : g_pair
      assign ext_rise[k]     = ext_lines[k] & ~ext_prev_q[k];
      // sticky edge bit: a new edge wins over a clearing write
      assign pend_d[2*k]     = ext_rise[k] | (pend_q[2*k] & ~(clr_en & clr_ext[k]));
      // level bit: tracks the line one clock late
      assign pend_d[2*k + 1] = int_lines[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_prev_q <= '0;
         pend_q     <= '0;
      end else begin
         ext_prev_q <= ext_lines;
         pend_q     <= pend_d;
      end
   end

endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
   parameter  int unsigned W         = 16,
   parameter  bit          LOW_FIRST = 1'b1,
   localparam int unsigned IDX_W     = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     req,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);

   assign hit = |req;

   if (LOW_FIRST) begin : g_low
      always_comb begin
         idx = '0;
         for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
         end
      end
   end else begin : g_high
      always_comb begin
         idx = '0;
         for (int i = 0; i < W; i++) begin
            if (req[i]) idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int unsigned W     = 16,
   parameter int unsigned VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             wr,
   input  logic [W-1:0]     wdata,
   input  logic [W-1:0]     pend,
   input  logic [VEC_W-1:0] vec,
   output logic [W-1:0]     mask_q,
   output logic             clr_en,
   output logic [W-1:0]     rdata
);

   reg_sel_e sel_e;
   assign sel_e  = reg_sel_e'(sel);
   assign clr_en = wr && (sel_e == SEL_PEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mask_q <= '0;
      else if (wr && (sel_e == SEL_MASK))  mask_q <= wdata;
   end

   always_comb begin
      unique case (sel_e)
         SEL_PEND: rdata = pend;
         SEL_MASK: rdata = mask_q;
         SEL_VEC:  rdata = W'(vec);
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import irqc_pkg::*;
#(
   parameter  int unsigned      PAIRS       = 8,
   parameter  int unsigned      STRIDE_LOG2 = 2,
   parameter  int unsigned      VEC_W       = 8,
   parameter  logic [VEC_W-1:0] NONE_CODE   = 8'hFF,
   parameter  bit               LOW_FIRST   = 1'b1,
   localparam int unsigned      NUM_SRC     = 2 * PAIRS,
   localparam int unsigned      IDX_W       = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PAIRS-1:0]   int_req_i,
   input  logic [PAIRS-1:0]   ext_req_i,
   input  logic [SEL_W-1:0]   bus_sel_i,
   input  logic               bus_wr_i,
   input  logic [NUM_SRC-1:0] bus_wdata_i,
   output logic [NUM_SRC-1:0] bus_rdata_o,
   output logic               irq_o
);

   if (PAIRS < 1) begin : g_chk_pairs
      $error("vec_irq_ctrl: PAIRS must be at least 1");
   end
   if (((NUM_SRC - 1) << STRIDE_LOG2) >= int'(NONE_CODE)) begin : g_chk_code
      $error("vec_irq_ctrl: largest vector collides with the idle code");
   end
   if (NUM_SRC < VEC_W) begin : g_chk_width
      $error("vec_irq_ctrl: read port narrower than vector code");
   end

   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] active;
   logic [PAIRS-1:0]   clr_ext;
   logic               clr_en;
   logic               hit;
   logic [IDX_W-1:0]   win_idx;
   logic [VEC_W-1:0]   vec_d;
   logic [VEC_W-1:0]   vec_q;
   logic               irq_q;

   for (genvar k = 0; k < PAIRS; k++) begin : g_clr
      assign clr_ext[k] = bus_wdata_i[2*k];
   end

   irqc_pending #(.PAIRS(PAIRS)) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_lines (ext_req_i),
      .int_lines (int_req_i),
      .clr_en    (clr_en),
      .clr_ext   (clr_ext),
      .pend_q    (pend_q)
   );

   assign active = pend_q & mask_q;

   irqc_prio_enc #(.W(NUM_SRC), .LOW_FIRST(LOW_FIRST)) u_enc (
      .req (active),
      .hit (hit),
      .idx (win_idx)
   );

   assign vec_d = hit ? (VEC_W'(win_idx) << STRIDE_LOG2) : NONE_CODE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q <= NONE_CODE;
         irq_q <= 1'b0;
      end else begin
         vec_q <= vec_d;
         irq_q <= hit;
      end
   end

   irqc_regs #(.W(NUM_SRC), .VEC_W(VEC_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (bus_sel_i),
      .wr     (bus_wr_i),
      .wdata  (bus_wdata_i),
      .pend   (pend_q),
      .vec    (vec_q),
      .mask_q (mask_q),
      .clr_en (clr_en),
      .rdata  (bus_rdata_o)
   );

   assign irq_o = irq_q;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter  int unsigned      PAIRS       = 8,
   parameter  int unsigned      STRIDE_LOG2 = 2,
   parameter  int unsigned      VEC_W       = 8,
   parameter  logic [VEC_W-1:0] NONE_CODE   = 8'hFF,
   localparam int unsigned      W           = 2 * PAIRS
) (
   input logic             clk,
   input logic             rst_n,
   input logic [PAIRS-1:0] int_req,
   input logic [1:0]       sel,
   input logic             wr,
   input logic [W-1:0]     wdata,
   input logic             irq,
   input logic [W-1:0]     pend,
   input logic [W-1:0]     mask,
   input logic [VEC_W-1:0] vec
);

   logic             armed;
   logic [W-1:0]     act_q;
   logic [PAIRS-1:0] int_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         act_q <= '0;
         int_q <= '0;
      end else begin
         armed <= 1'b1;
         act_q <= pend & mask;
         int_q <= int_req;
      end
   end

   AST_IRQ_TRACKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (irq == (act_q != '0))); // R6
   AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> (vec == NONE_CODE)); // R8
   AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && irq) |-> ((act_q & (~act_q + 1'b1)) == (W'(1) << (vec >> STRIDE_LOG2)))); // R7
   AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == 2'd1) |=> (mask == $past(wdata))); // R5
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && sel == 2'd1) |=> $stable(mask)); // R5

   for (genvar k = 0; k < PAIRS; k++) begin : g_src
      AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (pend[2*k] && !(wr && sel == 2'd0 && wdata[2*k])) |=> pend[2*k]); // R3
      AST_INT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
         armed |-> (pend[2*k+1] == int_q[k])); // R4
   end

endmodule

bind vec_irq_ctrl irqc_checker #(
   .PAIRS(PAIRS), .STRIDE_LOG2(STRIDE_LOG2), .VEC_W(VEC_W), .NONE_CODE(NONE_CODE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .int_req (int_req_i),
   .sel     (bus_sel_i),
   .wr      (bus_wr_i),
   .wdata   (bus_wdata_i),
   .irq     (irq_o),
   .pend    (pend_q),
   .mask    (mask_q),
   .vec     (vec_q)
);

// File: tb/vec_irq_ctrl_test.sv
`timescale 1ns/1ps
module vec_irq_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  int_req = '0;
   logic [7:0]  ext_req = '0;
   logic [1:0]  sel = '0;
   logic        wr = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vec_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .int_req_i(int_req), .ext_req_i(ext_req),
      .bus_sel_i(sel), .bus_wr_i(wr), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .irq_o(irq)
   );

   typedef struct packed {
      logic [7:0]  ints;
      logic [7:0]  exts;
      logic [15:0] mask;
      logic [7:0]  vec;
      logic        irq;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{8'h00, 8'h00, 16'hFFFF, 8'hFF, 1'b0},
      '{8'h01, 8'h00, 16'hFFFF, 8'h04, 1'b1},
      '{8'h00, 8'h01, 16'hFFFF, 8'h00, 1'b1},
      '{8'h80, 8'h80, 16'hFFFF, 8'h38, 1'b1},
      '{8'h80, 8'h00, 16'hFFFF, 8'h3C, 1'b1},
      '{8'hFF, 8'hFF, 16'h0000, 8'hFF, 1'b0},
      '{8'hFF, 8'hFF, 16'h8000, 8'h3C, 1'b1},
      '{8'h0C, 8'h30, 16'hFFFF, 8'h14, 1'b1},
      '{8'h0C, 8'h30, 16'hFF5F, 8'h20, 1'b1},
      '{8'h00, 8'h40, 16'h0000, 8'hFF, 1'b0}
   };

   function automatic logic [15:0] weave(input logic [7:0] e, input logic [7:0] i);
      logic [15:0] p;
      for (int k = 0; k < 8; k++) begin
         p[2*k]   = e[k];
         p[2*k+1] = i[k];
      end
      return p;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // called just after a negedge; returns just after the next negedge
   task automatic bus_write(input logic [1:0] s, input logic [15:0] d);
      sel = s; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic bus_read(input logic [1:0] s, output logic [15:0] d);
      sel = s;
      #1;
      d = rdata;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #500000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] v;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      // reset state
      bus_read(2'd0, v); check("R8 reset pending", 32'(v), 32'h0);
      bus_read(2'd1, v); check("R8 reset mask", 32'(v), 32'h0);
      bus_read(2'd2, v); check("R8 reset vector", 32'(v), 32'h00FF);
      check("R8 reset irq", 32'(irq), 32'h0);
      bus_read(2'd3, v); check("R9 reserved reads zero", 32'(v), 32'h0);
      wait_n(0);
      @(negedge clk);

      // vector table walk
      for (int i = 0; i < NV; i++) begin
         int_req = '0; ext_req = '0;
         wait_n(1);
         bus_write(2'd0, 16'hFFFF);
         bus_write(2'd1, TBL[i].mask);
         int_req = TBL[i].ints; ext_req = TBL[i].exts;
         wait_n(2);
         bus_read(2'd0, v);
         check($sformatf("R1 R2 table %0d pending", i), 32'(v), 32'(weave(TBL[i].exts, TBL[i].ints)));
         bus_read(2'd2, v);
         check($sformatf("R7 R8 table %0d vector", i), 32'(v), {24'h0, TBL[i].vec});
         check($sformatf("R6 table %0d irq", i), 32'(irq), 32'(TBL[i].irq));
         @(negedge clk);
      end

      // sticky pin source: one-cycle pulse
      int_req = '0; ext_req = '0;
      wait_n(1);
      bus_write(2'd0, 16'hFFFF);
      bus_write(2'd1, 16'hFFFF);
      ext_req[0] = 1'b1;
      wait_n(1);
      ext_req[0] = 1'b0;
      wait_n(1);
      bus_read(2'd0, v); check("R3 pulse latched", 32'(v), 32'h0001);
      bus_read(2'd2, v); check("R7 bit0 wins code 0", 32'(v), 32'h0000);
      check("R6 irq on pulse", 32'(irq), 32'h1);
      @(negedge clk);
      bus_write(2'd0, 16'hFFFE);
      bus_read(2'd0, v); check("R3 write zero keeps bit", 32'(v), 32'h0001);
      @(negedge clk);
      bus_write(2'd0, 16'h0001);
      bus_read(2'd0, v); check("R3 write one clears", 32'(v), 32'h0000);
      wait_n(1);
      check("R8 irq low when idle", 32'(irq), 32'h0);
      bus_read(2'd2, v); check("R8 idle code", 32'(v), 32'h00FF);
      @(negedge clk);

      // held-high line does not retrigger
      ext_req[2] = 1'b1;
      wait_n(2);
      bus_read(2'd0, v); check("R3 held line sets", 32'(v), 32'h0010);
      @(negedge clk);
      bus_write(2'd0, 16'h0010);
      wait_n(2);
      bus_read(2'd0, v); check("R3 held line no retrigger", 32'(v), 32'h0000);
      ext_req[2] = 1'b0;
      @(negedge clk);

      // edge in the same cycle as a clearing write
      ext_req[1] = 1'b1;
      bus_write(2'd0, 16'h0004);
      bus_read(2'd0, v); check("R3 edge beats clear", 32'(v), 32'h0004);
      ext_req = '0;
      @(negedge clk);
      bus_write(2'd0, 16'hFFFF);

      // level bits ignore writes and follow the line
      int_req[0] = 1'b1;
      wait_n(1);
      bus_write(2'd0, 16'hFFFF);
      bus_read(2'd0, v); check("R4 level bit ignores clear", 32'(v), 32'h0002);
      int_req[0] = 1'b0;
      wait_n(1);
      bus_read(2'd0, v); check("R4 level bit follows line", 32'(v), 32'h0000);
      @(negedge clk);

      // vector and reserved selects are read-only
      int_req[3] = 1'b1;
      wait_n(2);
      bus_read(2'd2, v); check("R7 peripheral 3 code", 32'(v), 32'h001C);
      @(negedge clk);
      bus_write(2'd2, 16'h0000);
      bus_read(2'd2, v); check("R9 vector write ignored", 32'(v), 32'h001C);
      @(negedge clk);
      bus_write(2'd3, 16'hFFFF);
      bus_read(2'd3, v); check("R9 reserved stays zero", 32'(v), 32'h0000);
      bus_read(2'd1, v); check("R9 R5 mask untouched", 32'(v), 32'hFFFF);
      @(negedge clk);

      // mask readback and masking of the only source
      bus_write(2'd1, 16'hA5C3);
      bus_read(2'd1, v); check("R5 mask readback", 32'(v), 32'hA5C3);
      @(negedge clk);
      bus_write(2'd1, 16'h0000);
      wait_n(1);
      check("R6 irq drops when masked", 32'(irq), 32'h0);
      bus_read(2'd2, v); check("R8 masked gives idle code", 32'(v), 32'h00FF);
      bus_read(2'd0, v); check("R2 masked source still pending", 32'(v), 32'h0080);

      finish_run();
   end

endmodule